// File: doc/BRIEF.md
# Program Status Flag Unit with Sticky Saturation

This block keeps the arithmetic condition flags of a 32-bit datapath: negative, zero, carry, overflow and a sticky saturation flag. Each cycle it can take its flags from an external ALU result with carry and overflow indications. It can also run its own add, subtract, saturating add or saturating subtract on two operands. The saturating forms clamp to the largest or smallest signed value when the exact result does not fit. When that happens they set the saturation flag, which only an explicit write can clear.

A masked write port loads or clears any subset of the five flags. The block also packs the flags, a constant execution-state bit and the number of the active handler into one 32-bit status word. The word is laid out so that software can read all of them at once. The arithmetic result of the selected operation is available combinationally on `res_out`.

Flags are registered: an update or write presented before a rising edge is visible on the flag outputs and in the status word after that edge. The handler number passes straight through to the status word.

Top module: `psw_flag_unit`

## Requirements
- R1: Reset (active-low `rst_n`) clears all five flags, so that the status word reads `0x01000000` with handler number 0.
- R2: On an update, N takes bit 31 of the selected result and Z is set exactly when that result is zero. The op codes are 0 external, 1 add, 2 subtract, 3 saturating add and 4 saturating subtract.
- R3: For op 0, C and V copy `alu_carry` and `alu_ovf`. For op 1, C is the unsigned carry out of `a + b`. For op 2, C is 1 when `a >= b` as unsigned values, meaning no borrow.
- R4: For ops 1 and 2, V is set exactly when the two's-complement result differs from the exact signed result.
- R5: For ops 3 and 4, `res_out` is the exact signed result when it fits. It is `0x7FFFFFFF` on positive overflow and `0x80000000` on negative overflow. For op 0 it is `alu_result`, and for ops 1 and 2 it is the 32-bit wrapped result.
- R6: A saturating op that clamps sets Q. Once set, Q stays 1 through any later updates until the write port clears it.
- R7: Ops 3 and 4 leave N, Z, C and V unchanged, and ops 0 to 2 never change Q.
- R8: With `upd_en` and `wr_en` both low, or with an op code of 5 to 7 and no write, no flag changes.
- R9: With `wr_en` high, each flag whose `wr_mask` bit is set loads the matching `wr_val` bit, with bit 4 for N, then Z, C, V, and bit 0 for Q. This write overrides an update to that flag in the same cycle, while flags whose mask bit is clear follow the update.
- R10: The status word holds N in bit 31, Z in bit 30, C in bit 29, V in bit 28, Q in bit 27, a constant 1 in bit 24, and `handler_num` in bits 8:0. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Apply the selected operation to the flags |
| op | input | 3 | Operation code (0 external, 1 add, 2 sub, 3 sat add, 4 sat sub) |
| alu_result | input | 32 | External ALU result |
| alu_carry | input | 1 | External carry indication |
| alu_ovf | input | 1 | External signed overflow indication |
| opnd_a | input | 32 | First internal operand (minuend) |
| opnd_b | input | 32 | Second internal operand (subtrahend) |
| wr_en | input | 1 | Flag write strobe |
| wr_mask | input | 5 | Per-flag write select, N at bit 4 down to Q at bit 0 |
| wr_val | input | 5 | Values to load, same bit order |
| handler_num | input | 9 | Active handler number |
| res_out | output | 32 | Result of the selected operation |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_q | output | 1 | Sticky saturation flag |
| status_word | output | 32 | Combined status word |

## Verification
The hardest case to reach is a write and an update that hit the same cycle with a partial mask. Some flags must then take the written value while the others follow the arithmetic. For Q, a clamp and a clearing write compete directly. The stimulus drives directed collisions with mixed masks during clamping saturating ops, and then a random phase in which writes and clamps overlap often. A scoreboard of wide-arithmetic expectations checks every cycle's status word.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
    typedef enum logic [2:0] {
        OP_EXT  = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_QADD = 3'd3,
        OP_QSUB = 3'd4
    } psw_op_e;

    // bit 4 = N ... bit 0 = Q
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
        logic q;
    } psw_flags_t;

    localparam int NUM_FLAGS = 5;
endpackage

// File: rtl/psw_addsub.sv
`timescale 1ns/1ps
module psw_addsub
    import psw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          carry,
    output logic          ovf,
    output logic          clamp
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic          is_sub;
    logic          is_sat;
    logic [DW-1:0] b_eff;
    logic [DW:0]   sum;
    logic [DW-1:0] raw;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_QSUB);
        is_sat = (op == OP_QADD) || (op == OP_QSUB);
        b_eff  = is_sub ? ~b : b;
        sum    = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, is_sub};
        raw    = sum[DW-1:0];
        carry  = sum[DW];
        ovf    = (a[DW-1] == b_eff[DW-1]) && (raw[DW-1] != a[DW-1]);
        clamp  = is_sat && ovf;
        if (clamp) res = a[DW-1] ? SMIN : SMAX;
        else       res = raw;
    end
endmodule

// File: rtl/psw_flag_reg.sv
`timescale 1ns/1ps
module psw_flag_reg
    import psw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_nzcv,
    input  logic                 set_q,
    input  logic [3:0]           nzcv_new,
    input  logic                 wr_en,
    input  logic [NUM_FLAGS-1:0] wr_mask,
    input  logic [NUM_FLAGS-1:0] wr_val,
    output psw_flags_t           flags
);
    logic [NUM_FLAGS-1:0] cur;
    logic [NUM_FLAGS-1:0] upd_bits;
    logic [NUM_FLAGS-1:0] nxt;

    assign cur = flags;

    always_comb begin
        upd_bits = cur;
        if (upd_nzcv) upd_bits[4:1] = nzcv_new;
        if (set_q)    upd_bits[0]   = 1'b1;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_merge
        assign nxt[i] = (wr_en && wr_mask[i]) ? wr_val[i] : upd_bits[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= nxt;
    end
endmodule

// File: rtl/psw_word_pack.sv
`timescale 1ns/1ps
module psw_word_pack
    import psw_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 9
) (
    input  psw_flags_t    flags,
    input  logic [HW-1:0] handler,
    output logic [DW-1:0] word
);
    localparam int T_POS = DW - 8;

    always_comb begin
        word             = '0;
        word[DW-1]       = flags.n;
        word[DW-2]       = flags.z;
        word[DW-3]       = flags.c;
        word[DW-4]       = flags.v;
        word[DW-5]       = flags.q;
        word[T_POS]      = 1'b1;
        word[HW-1:0]     = handler;
    end
endmodule

// File: rtl/psw_flag_unit.sv
`timescale 1ns/1ps
module psw_flag_unit
    import psw_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic [2:0]    op,
    input  logic [DW-1:0] alu_result,
    input  logic          alu_carry,
    input  logic          alu_ovf,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          wr_en,
    input  logic [4:0]    wr_mask,
    input  logic [4:0]    wr_val,
    input  logic [HW-1:0] handler_num,
    output logic [DW-1:0] res_out,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c,
    output logic          flag_v,
    output logic          flag_q,
    output logic [DW-1:0] status_word
);
    logic [DW-1:0] int_res;
    logic          int_c;
    logic          int_v;
    logic          int_clamp;
    logic          is_ext;
    logic          is_plain;
    logic          sel_c;
    logic          sel_v;
    logic          upd_nzcv;
    logic          set_q;
    psw_flags_t    flags;

    psw_addsub #(.DW(DW)) u_addsub (
        .op(op), .a(opnd_a), .b(opnd_b),
        .res(int_res), .carry(int_c), .ovf(int_v), .clamp(int_clamp)
    );

    always_comb begin
        is_ext   = (op == OP_EXT);
        is_plain = is_ext || (op == OP_ADD) || (op == OP_SUB);
        res_out  = is_ext ? alu_result : int_res;
        sel_c    = is_ext ? alu_carry  : int_c;
        sel_v    = is_ext ? alu_ovf    : int_v;
        upd_nzcv = upd_en && is_plain;
        set_q    = upd_en && int_clamp;
    end

    psw_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n),
        .upd_nzcv(upd_nzcv), .set_q(set_q),
        .nzcv_new({res_out[DW-1], (res_out == '0), sel_c, sel_v}),
        .wr_en(wr_en), .wr_mask(wr_mask), .wr_val(wr_val),
        .flags(flags)
    );

    psw_word_pack #(.DW(DW), .HW(HW)) u_pack (
        .flags(flags), .handler(handler_num), .word(status_word)
    );

    assign flag_n = flags.n;
    assign flag_z = flags.z;
    assign flag_c = flags.c;
    assign flag_v = flags.v;
    assign flag_q = flags.q;
endmodule

// File: rtl/psw_flag_chk.sv
`timescale 1ns/1ps
module psw_flag_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_en,
    input logic [2:0]  op,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic        wr_en,
    input logic [4:0]  wr_mask,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_c,
    input logic        flag_v,
    input logic        flag_q,
    input logic [31:0] res_out,
    input logic [31:0] status_word
);
    logic signed [32:0] wide;
    logic               exact_ovf;
    logic               sat_op;

    always_comb begin
        sat_op = (op == 3'd3) || (op == 3'd4);
        if (op == 3'd4) wide = {opnd_a[31], opnd_a} - {opnd_b[31], opnd_b};
        else            wide = {opnd_a[31], opnd_a} + {opnd_b[31], opnd_b};
        exact_ovf = wide[32] != wide[31];
    end

    assert_pos_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_op && exact_ovf && !wide[32]) |-> (res_out == 32'h7FFF_FFFF));

    assert_neg_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_op && exact_ovf && wide[32]) |-> (res_out == 32'h8000_0000));

    assert_q_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && sat_op && exact_ovf && !(wr_en && wr_mask[0])) |=> flag_q);

    assert_q_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en && wr_mask[0])) |=> flag_q);

    assert_sat_keeps_nzcv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && sat_op && !wr_en) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !wr_en) |=> $stable({flag_n, flag_z, flag_c, flag_v, flag_q}));

    assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (op <= 3'd2) && !wr_en) |=> (flag_z == ($past(res_out) == 32'd0)));

    assert_word_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[31:27] == {flag_n, flag_z, flag_c, flag_v, flag_q});
endmodule

bind psw_flag_unit psw_flag_chk u_psw_flag_chk (.*);

// File: tb/test_psw_flag_unit.sv
`timescale 1ns/1ps
module test_psw_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] alu_result = '0;
    logic        alu_carry = 1'b0;
    logic        alu_ovf = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_mask = '0;
    logic [4:0]  wr_val = '0;
    logic [8:0]  handler_num = '0;
    logic [31:0] res_out;
    logic        flag_n, flag_z, flag_c, flag_v, flag_q;
    logic [31:0] status_word;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [4:0] m_flags = '0;     // model: N Z C V Q
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    psw_flag_unit i_psw_flag_unit (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op(op),
        .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .wr_en(wr_en), .wr_mask(wr_mask),
        .wr_val(wr_val), .handler_num(handler_num), .res_out(res_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .flag_q(flag_q), .status_word(status_word)
    );

    function automatic logic [31:0] mkword(logic [4:0] f, logic [8:0] h);
        return {f, 2'b00, 1'b1, 15'd0, h};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic upd, input logic [2:0] o,
                        input logic [31:0] er, input logic ec, input logic ev,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic wr, input logic [4:0] m, input logic [4:0] wv,
                        input logic [8:0] h, input string tag);
        longint sa, sb, s;
        logic [32:0] u;
        logic [31:0] r;
        logic c, v, clamp;
        logic [4:0] nf;
        @(negedge clk);
        upd_en = upd; op = o; alu_result = er; alu_carry = ec; alu_ovf = ev;
        opnd_a = a; opnd_b = b; wr_en = wr; wr_mask = m; wr_val = wv;
        handler_num = h;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        clamp = 1'b0;
        c = ec; v = ev; r = er;
        if (o == 3'd2 || o == 3'd4) begin
            s = sa - sb;
            c = (a >= b);
            r = a - b;
        end else begin
            s = sa + sb;
            u = {1'b0, a} + {1'b0, b};
            c = u[32];
            r = u[31:0];
        end
        if (o == 3'd0) begin
            c = ec; v = ev; r = er;
        end else begin
            v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end
        if (o == 3'd3 || o == 3'd4) begin
            if (s > 64'sd2147483647) begin r = 32'h7FFF_FFFF; clamp = 1'b1; end
            else if (s < -64'sd2147483648) begin r = 32'h8000_0000; clamp = 1'b1; end
            else r = s[31:0];
        end
        nf = m_flags;
        if (upd && o <= 3'd2) nf[4:1] = {r[31], r == 32'd0, c, v};
        if (upd && clamp) nf[0] = 1'b1;
        for (int i = 0; i < 5; i++) if (wr && m[i]) nf[i] = wv[i];
        m_flags = nf;
        if (o <= 3'd4) begin
            #1 check({tag, " R5 res_out"}, res_out, r);
        end
        exp_q.push_back(mkword(nf, h));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic [8:0] h);
        step(1'b0, 3'd0, 32'd0, 1'b0, 1'b0, 32'd0, 32'd0, 1'b0, 5'd0, 5'd0, h, "R8 R10 idle");
    endtask

    // monitor: compares one queued expectation after every rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " status_word"}, status_word, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset status word", status_word, 32'h0100_0000);
        rst_n = 1'b1;
        // R2 R3 R4 external op
        step(1, 3'd0, 32'h8000_0001, 1, 0, 0, 0, 0, 0, 0, 9'h005, "R2 R3 external neg");
        step(1, 3'd0, 32'h0000_0000, 0, 1, 0, 0, 0, 0, 0, 9'h1FF, "R2 R4 R10 external zero");
        // add carry and zero
        step(1, 3'd1, 0, 0, 0, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 9'h010, "R2 R3 add wrap");
        step(1, 3'd1, 0, 0, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 9'h011, "R4 add signed ovf");
        // sub carry as no borrow
        step(1, 3'd2, 0, 0, 0, 32'h1234, 32'h1234, 0, 0, 0, 9'h0, "R3 sub equal");
        step(1, 3'd2, 0, 0, 0, 32'h0, 32'h1, 0, 0, 0, 9'h0, "R3 sub borrow");
        step(1, 3'd2, 0, 0, 0, 32'h8000_0000, 32'h1, 0, 0, 0, 9'h0, "R4 sub signed ovf");
        // saturation
        step(1, 3'd3, 0, 0, 0, 32'h1, 32'h2, 0, 0, 0, 9'h0, "R5 R7 qadd no clamp");
        step(1, 3'd3, 0, 0, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 9'h0, "R5 R6 R7 qadd pos clamp");
        step(1, 3'd1, 0, 0, 0, 32'h1, 32'h1, 0, 0, 0, 9'h0, "R6 R7 q sticky add");
        step(1, 3'd0, 32'h5, 0, 0, 0, 0, 0, 0, 0, 9'h0, "R6 q sticky external");
        step(1, 3'd4, 0, 0, 0, 32'h8000_0000, 32'h1, 0, 0, 0, 9'h0, "R5 R6 qsub neg clamp");
        step(1, 3'd3, 0, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0, 9'h0, "R5 qadd neg clamp");
        step(1, 3'd4, 0, 0, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 9'h0, "R5 qsub pos clamp");
        // write port
        step(0, 3'd0, 0, 0, 0, 0, 0, 1, 5'b00001, 5'b00000, 9'h0, "R6 R9 write clears Q");
        idle(9'h0AA);
        step(0, 3'd0, 0, 0, 0, 0, 0, 1, 5'b11111, 5'b10101, 9'h0, "R9 write all");
        step(1, 3'd3, 0, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 5'b00001, 5'b00000, 9'h0, "R9 R6 write beats clamp");
        step(1, 3'd1, 0, 0, 0, 32'h0, 32'h0, 1, 5'b10010, 5'b10010, 9'h0, "R9 partial mask over add");
        // invalid codes and idle hold
        step(1, 3'd5, 0, 0, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 9'h0, "R8 op 5");
        step(1, 3'd7, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0, 9'h0, "R8 op 7");
        step(0, 3'd3, 0, 0, 0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 9'h0, "R8 clamp without update");
        idle(9'h100);
        // random phase
        for (int k = 0; k < 600; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (k % 7 == 0) ra = {ra[31], {31{~ra[31]}}};
            step($urandom_range(0, 3) != 0, 3'($urandom_range(0, 5)), $urandom,
                 1'($urandom), 1'($urandom), ra, rb,
                 $urandom_range(0, 3) == 0, 5'($urandom), 5'($urandom),
                 9'($urandom), "R2 R3 R4 R5 R6 R7 R9 R10 random");
        end
        idle(9'h0);
        idle(9'h0);
        @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule